// File: doc/BRIEF.md
# Multi-Channel Stream Ingress Aggregator

This block collects traffic from a link receiver that delivers frames on several virtual channels, each on its own slave stream with 64-bit data and an end-of-frame marker. Every channel owns a private FIFO. A round-robin arbiter drains the FIFOs into one master stream. The output tags each word with the index of the channel it came from. A grant lasts until the end of a frame or until a fixed number of words has gone out, whichever comes first.

Two conditions gate ingress. While the link is reported not ready, the block takes every word offered and throws it away, so the receiver never stalls. This discard only begins or ends between frames, so no FIFO ever holds a truncated frame. A per-channel pause vector arrives from another clock domain and passes through a two-stage synchroniser. A paused channel lowers its ready and leaves the data waiting at its source.

The data width is fixed at 64 bits. The channel count, FIFO depth and burst limit are parameters. The production configuration uses four channels, a depth of 4096 words and a burst limit of 128. The default depth is smaller so that the default elaboration stays small.

Top module: `ingress_stream_aggregator`

## Requirements
- R1: After synchronous reset, with the link ready and no channel paused, m_tvalid is low and every s_tready bit is high.
- R2: A frame whose first word is accepted while link_ready is low is discarded entirely: s_tready stays high for each of its words and none of them appears on the output.
- R3: The discard state changes only on a frame boundary. A frame that started with the link ready is delivered whole even if link_ready falls mid-frame. A frame that started while the link was down is discarded whole even if link_ready rises mid-frame.
- R4: Setting bit i of pause_async drives s_tready[i] low within three clock cycles, unless channel i is discarding. Other channels are unaffected. Words held during the pause are delivered after it clears.
- R5: Every accepted, non-discarded word appears exactly once on the output, in arrival order for its channel. m_tdest carries the channel index (0 to CH_NUM-1), and m_tlast is reproduced on the frame's final word.
- R6: One grant emits at most BURST_MAX (default 128) words. When a grant hits that limit and another channel holds data, the next word comes from the other channel.
- R7: A grant ends after a word with m_tlast set. The next grant goes to the first channel holding data, searching upward from the channel just served and wrapping from CH_NUM-1 to 0. After reset, channel 0 has highest priority.
- R8: A channel's FIFO accepts exactly FIFO_DEPTH words while the output is stalled, then holds s_tready low until space frees up. No word is lost.
- R9: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata, m_tlast and m_tdest stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link-side clock |
| rst | input | 1 | Synchronous active-high reset |
| link_ready | input | 1 | High when the link receiver reports a usable link |
| pause_async | input | CH_NUM | Per-channel pause request from the host clock domain |
| s_tvalid | input | CH_NUM | Per-channel input word valid |
| s_tdata | input | CH_NUM*64 | Per-channel input data, channel i in bits [64*i+63:64*i] |
| s_tlast | input | CH_NUM | Per-channel end-of-frame marker |
| s_tready | output | CH_NUM | Per-channel input ready |
| m_tvalid | output | 1 | Merged output valid |
| m_tdata | output | 64 | Merged output data |
| m_tlast | output | 1 | Merged output end-of-frame marker |
| m_tdest | output | $clog2(CH_NUM) | Channel index of the current output word |
| m_tready | input | 1 | Downstream ready |

## Verification
The hardest conditions to reach from the ports are a grant cut off by the burst limit and a completely full channel FIFO. Both need the FIFOs filled well past their normal occupancy before the arbiter runs. The stimulus reaches them by holding m_tready low while long frames are loaded, then opening the output and recording the sequence of per-channel runs. Link-drop and pause edges that fall mid-frame are placed by waiting on the count of accepted words. A constrained-random phase then mixes these effects across all channels at once.

// File: rtl/ingress_agg_pkg.sv
package ingress_agg_pkg;

    localparam int AGG_DATA_W = 64;
    localparam int AGG_MAX_CH = 16;

    typedef struct packed {
        logic [AGG_DATA_W-1:0] data;
        logic                  last;
    } agg_beat_t;

    typedef enum logic [1:0] {
        GATE_IDLE,
        GATE_PASS,
        GATE_DROP
    } gate_state_e;

    typedef enum logic {
        ARB_SEEK,
        ARB_HOLD
    } arb_state_e;

    // Round-robin search: first requester after 'last', wrapping at n.
    // Result bit 4 flags a hit, bits 3:0 hold the index.
    function automatic logic [4:0] rr_pick(input logic [AGG_MAX_CH-1:0] req,
                                           input logic [3:0] last,
                                           input int n);
        logic [4:0] res;
        int idx;
        res = '0;
        for (int k = AGG_MAX_CH; k >= 1; k--) begin
            if (k <= n) begin
                idx = (int'(last) + k) % n;
                if (req[idx]) res = {1'b1, 4'(idx)};
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/agg_pause_sync.sv
module agg_pause_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage1[i] <= 1'b0;
                    stage2[i] <= 1'b0;
                end else begin
                    stage1[i] <= d_async[i];
                    stage2[i] <= stage1[i];
                end
            end

            // A rising synchronised pause must trace back to the input two edges earlier.
            assert_sync_delay_R4: assert property (@(posedge clk) disable iff (rst)
                $rose(stage2[i]) |-> $past(d_async[i], 2));
        end
    endgenerate

    assign q_sync = stage2;

endmodule

// File: rtl/agg_ingress_gate.sv
module agg_ingress_gate
    import ingress_agg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      link_ready,
    input  logic      paused,
    input  logic      s_valid,
    input  agg_beat_t s_beat,
    output logic      s_ready,
    input  logic      fifo_full,
    output logic      push
);

    gate_state_e st;
    logic        drop_now;
    logic        accept;

    // The discard decision is taken at frame start and held to tlast.
    always_comb begin
        drop_now = (st == GATE_DROP) || ((st == GATE_IDLE) && !link_ready);
        s_ready  = drop_now ? 1'b1 : (!paused && !fifo_full);
        accept   = s_valid && s_ready;
        push     = accept && !drop_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= GATE_IDLE;
        end else if (accept) begin
            if (s_beat.last)   st <= GATE_IDLE;
            else if (drop_now) st <= GATE_DROP;
            else               st <= GATE_PASS;
        end
    end

    // Mode changes only pass through a frame boundary.
    assert_pass_stays_R3: assert property (@(posedge clk) disable iff (rst)
        (st == GATE_PASS) |=> (st != GATE_DROP));
    assert_drop_stays_R3: assert property (@(posedge clk) disable iff (rst)
        (st == GATE_DROP) |=> (st != GATE_PASS));
    // A discarding channel never back-pressures the receiver.
    assert_drop_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (st == GATE_DROP) |-> (s_ready && !push));

endmodule

// File: rtl/agg_chan_fifo.sv
module agg_chan_fifo
    import ingress_agg_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  agg_beat_t push_beat,
    input  logic      pop,
    output agg_beat_t head,
    output logic      not_empty,
    output logic      full
);

    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_L = (AW+1)'(DEPTH);

    agg_beat_t   mem [DEPTH];
    logic [AW:0] wr_ptr;
    logic [AW:0] rd_ptr;
    logic [AW:0] level;

    always_comb begin
        level     = wr_ptr - rd_ptr;
        full      = (level == DEPTH_L);
        not_empty = (level != '0);
        head      = mem[rd_ptr[AW-1:0]];
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[AW-1:0]] <= push_beat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> not_empty);

endmodule

// File: rtl/agg_burst_arb.sv
module agg_burst_arb
    import ingress_agg_pkg::*;
#(
    parameter int CH_NUM    = 4,
    parameter int BURST_MAX = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CH_NUM-1:0] head_valid,
    input  agg_beat_t         head_beat [CH_NUM],
    output logic [CH_NUM-1:0] pop,
    output logic              m_valid,
    output agg_beat_t         m_beat,
    output logic [((CH_NUM > 1) ? $clog2(CH_NUM) : 1)-1:0] m_dest,
    input  logic              m_ready
);

    localparam int CW    = (CH_NUM > 1) ? $clog2(CH_NUM) : 1;
    localparam int CNT_W = (BURST_MAX > 1) ? $clog2(BURST_MAX) : 1;
    localparam logic [CNT_W-1:0] CAP = CNT_W'(BURST_MAX - 1);
    localparam int TRACK_W = $clog2(BURST_MAX + 2);

    arb_state_e       st;
    logic [CW-1:0]    cur;
    logic [CW-1:0]    last_ch;
    logic [CNT_W-1:0] cnt;
    logic [4:0]       pick;
    logic             fire;

    always_comb begin
        pick    = rr_pick(AGG_MAX_CH'(head_valid), 4'(last_ch), CH_NUM);
        m_valid = (st == ARB_HOLD) && head_valid[cur];
        m_beat  = head_beat[cur];
        m_dest  = cur;
        fire    = m_valid && m_ready;
        pop     = '0;
        if (fire) pop[cur] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ARB_SEEK;
            cur     <= '0;
            last_ch <= CW'(CH_NUM - 1);
            cnt     <= '0;
        end else begin
            case (st)
                ARB_SEEK: begin
                    if (pick[4]) begin
                        cur <= CW'(pick[3:0]);
                        cnt <= '0;
                        st  <= ARB_HOLD;
                    end
                end
                default: begin
                    if (fire) begin
                        if (m_beat.last || cnt == CAP) begin
                            st      <= ARB_SEEK;
                            last_ch <= cur;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // Independent tally of words sent since the grant began.
    logic [TRACK_W-1:0] grant_words;
    always_ff @(posedge clk) begin
        if (rst || st == ARB_SEEK) grant_words <= '0;
        else if (fire)             grant_words <= grant_words + 1'b1;
    end

    assert_burst_cap_R6: assert property (@(posedge clk) disable iff (rst)
        grant_words <= TRACK_W'(BURST_MAX));
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_beat) && $stable(m_dest)));
    assert_single_pop_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pop));
    assert_tlast_release_R7: assert property (@(posedge clk) disable iff (rst)
        (fire && m_beat.last) |=> (st == ARB_SEEK));

endmodule

// File: rtl/ingress_stream_aggregator.sv
module ingress_stream_aggregator
    import ingress_agg_pkg::*;
#(
    parameter int CH_NUM     = 4,
    parameter int FIFO_DEPTH = 512,
    parameter int BURST_MAX  = 128
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         link_ready,
    input  logic [CH_NUM-1:0]            pause_async,
    input  logic [CH_NUM-1:0]            s_tvalid,
    input  logic [CH_NUM*AGG_DATA_W-1:0] s_tdata,
    input  logic [CH_NUM-1:0]            s_tlast,
    output logic [CH_NUM-1:0]            s_tready,
    output logic                         m_tvalid,
    output logic [AGG_DATA_W-1:0]        m_tdata,
    output logic                         m_tlast,
    output logic [((CH_NUM > 1) ? $clog2(CH_NUM) : 1)-1:0] m_tdest,
    input  logic                         m_tready
);

    logic [CH_NUM-1:0] pause_sync;
    logic [CH_NUM-1:0] fifo_push;
    logic [CH_NUM-1:0] fifo_pop;
    logic [CH_NUM-1:0] fifo_full;
    logic [CH_NUM-1:0] fifo_nempty;
    agg_beat_t         in_beat   [CH_NUM];
    agg_beat_t         fifo_head [CH_NUM];
    agg_beat_t         out_beat;

    agg_pause_sync #(.WIDTH(CH_NUM)) u_pause_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pause_async),
        .q_sync  (pause_sync)
    );

    generate
        for (genvar c = 0; c < CH_NUM; c++) begin : g_chan
            assign in_beat[c].data = s_tdata[c*AGG_DATA_W +: AGG_DATA_W];
            assign in_beat[c].last = s_tlast[c];

            agg_ingress_gate u_gate (
                .clk        (clk),
                .rst        (rst),
                .link_ready (link_ready),
                .paused     (pause_sync[c]),
                .s_valid    (s_tvalid[c]),
                .s_beat     (in_beat[c]),
                .s_ready    (s_tready[c]),
                .fifo_full  (fifo_full[c]),
                .push       (fifo_push[c])
            );

            agg_chan_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
                .clk       (clk),
                .rst       (rst),
                .push      (fifo_push[c]),
                .push_beat (in_beat[c]),
                .pop       (fifo_pop[c]),
                .head      (fifo_head[c]),
                .not_empty (fifo_nempty[c]),
                .full      (fifo_full[c])
            );
        end
    endgenerate

    agg_burst_arb #(.CH_NUM(CH_NUM), .BURST_MAX(BURST_MAX)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .head_valid (fifo_nempty),
        .head_beat  (fifo_head),
        .pop        (fifo_pop),
        .m_valid    (m_tvalid),
        .m_beat     (out_beat),
        .m_dest     (m_tdest),
        .m_ready    (m_tready)
    );

    assign m_tdata = out_beat.data;
    assign m_tlast = out_beat.last;

    // A word leaves only from a channel whose FIFO holds data.
    assert_pop_source_R5: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && m_tready) |-> fifo_nempty[m_tdest]);

endmodule

// File: tb/test_ingress_stream_aggregator.sv
module test_ingress_stream_aggregator;

    localparam int CH    = 4;
    localparam int DEPTH = 512;
    localparam int BURST = 128;

    logic            clk = 1'b0;
    logic            rst;
    logic            link_ready;
    logic [CH-1:0]   pause_async;
    logic [CH-1:0]   s_tvalid;
    logic [CH*64-1:0] s_tdata;
    logic [CH-1:0]   s_tlast;
    logic [CH-1:0]   s_tready;
    logic            m_tvalid;
    logic [63:0]     m_tdata;
    logic            m_tlast;
    logic [1:0]      m_tdest;
    logic            m_tready;

    always #10 clk = ~clk;

    ingress_stream_aggregator #(.CH_NUM(CH), .FIFO_DEPTH(DEPTH), .BURST_MAX(BURST)) i_ingress_stream_aggregator (
        .clk(clk), .rst(rst), .link_ready(link_ready), .pause_async(pause_async),
        .s_tvalid(s_tvalid), .s_tdata(s_tdata), .s_tlast(s_tlast), .s_tready(s_tready),
        .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tlast(m_tlast), .m_tdest(m_tdest),
        .m_tready(m_tready)
    );

    int checks = 0;
    int errors = 0;
    bit mid   [CH];
    bit drop  [CH];
    int accepted [CH];
    int seqn  [CH];
    int out_count [CH];
    logic [64:0] expq [CH][$];
    int run_d [$];
    int run_l [$];
    int cur_d = -1;
    int cur_l = 0;
    bit rand_ready = 0;
    bit hold_prev = 0;
    logic [63:0] prev_data;
    logic [1:0]  prev_dest;
    int drivers_done = 0;
    bit rand_on = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] word_of(input int ch, input int fr, input int idx);
        return {8'(ch), 24'(fr), 32'(idx)};
    endfunction

    // Drives one frame; the bench decides discard at the first accepted word.
    task automatic send_frame(input int ch, input int len);
        for (int i = 0; i < len; i++) begin
            logic [63:0] w;
            bit done;
            w = word_of(ch, seqn[ch], i);
            done = 0;
            while (!done) begin
                bit dr;
                @(negedge clk);
                s_tvalid[ch] = 1'b1;
                s_tdata[ch*64 +: 64] = w;
                s_tlast[ch] = (i == len - 1);
                #1;
                dr = mid[ch] ? drop[ch] : !link_ready;
                if (dr) check(s_tready[ch] == 1'b1, "R2 ready while discarding", 64'(s_tready[ch]), 64'd1);
                if (s_tready[ch]) begin
                    if (!dr) expq[ch].push_back({(i == len - 1), w});
                    drop[ch] = dr;
                    mid[ch]  = (i != len - 1);
                    accepted[ch]++;
                    done = 1;
                end
            end
        end
        @(negedge clk);
        s_tvalid[ch] = 1'b0;
        seqn[ch]++;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ready(input logic v);
        @(negedge clk);
        m_tready = v;
    endtask

    task automatic flush_runs();
        if (cur_l > 0) begin
            run_d.push_back(cur_d);
            run_l.push_back(cur_l);
        end
        cur_d = -1;
        cur_l = 0;
    endtask

    task automatic clear_runs();
        run_d.delete();
        run_l.delete();
        cur_d = -1;
        cur_l = 0;
    endtask

    // Output monitor and scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rand_ready) m_tready = (($urandom % 10) < 7);
            #2;
            if (!rst) begin
                if (hold_prev)
                    check(m_tvalid && m_tdata == prev_data && m_tdest == prev_dest,
                          "R9 output held under stall", m_tdata, prev_data);
                hold_prev = m_tvalid && !m_tready;
                prev_data = m_tdata;
                prev_dest = m_tdest;
                if (m_tvalid && m_tready) begin
                    int d;
                    d = int'(m_tdest);
                    out_count[d]++;
                    if (expq[d].size() == 0) begin
                        check(1'b0, "R5 unexpected word", m_tdata, 64'd0);
                    end else begin
                        logic [64:0] e;
                        e = expq[d].pop_front();
                        check({m_tlast, m_tdata} == e, "R5 order, data, tlast and tdest", {m_tlast, m_tdata}, e);
                    end
                    if (d == cur_d) cur_l++;
                    else begin
                        if (cur_l > 0) begin
                            run_d.push_back(cur_d);
                            run_l.push_back(cur_l);
                        end
                        cur_d = d;
                        cur_l = 1;
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int snap;
        int snap2;
        void'($urandom(32'd4242));
        rst = 1'b1;
        link_ready = 1'b1;
        pause_async = '0;
        s_tvalid = '0;
        s_tdata = '0;
        s_tlast = '0;
        m_tready = 1'b0;
        for (int c = 0; c < CH; c++) begin
            mid[c] = 0; drop[c] = 0; accepted[c] = 0; seqn[c] = 0; out_count[c] = 0;
        end
        wait_cycles(5);
        rst = 1'b0;
        wait_cycles(2);
        #1;
        // R1 reset state
        check(m_tvalid == 1'b0, "R1 m_tvalid after reset", 64'(m_tvalid), 64'd0);
        check(s_tready == 4'hF, "R1 s_tready after reset", 64'(s_tready), 64'hF);

        // R2 frame offered while the link is down is discarded
        link_ready = 1'b0;
        send_frame(0, 5);
        link_ready = 1'b1;
        set_ready(1'b1);
        wait_cycles(12);
        check(out_count[0] == 0, "R2 discarded frame not output", 64'(out_count[0]), 64'd0);

        // R3 link falls mid-frame: frame kept; link rises mid-frame: frame dropped
        snap = out_count[1];
        snap2 = accepted[1];
        fork
            send_frame(1, 6);
            begin
                wait (accepted[1] == snap2 + 2);
                @(negedge clk);
                link_ready = 1'b0;
            end
        join
        snap2 = accepted[2];
        fork
            send_frame(2, 4);
            begin
                wait (accepted[2] == snap2 + 2);
                @(negedge clk);
                link_ready = 1'b1;
            end
        join
        link_ready = 1'b1;
        wait_cycles(20);
        check(out_count[1] - snap == 6, "R3 frame started with link up delivered", 64'(out_count[1] - snap), 64'd6);
        check(out_count[2] == 0, "R3 frame started with link down dropped", 64'(out_count[2]), 64'd0);

        // R4 pause on channel 1
        @(negedge clk);
        pause_async = 4'b0010;
        wait_cycles(3);
        #1;
        check(s_tready[1] == 1'b0, "R4 paused channel not ready", 64'(s_tready[1]), 64'd0);
        check(s_tready[0] == 1'b1, "R4 other channel ready", 64'(s_tready[0]), 64'd1);
        snap = accepted[1];
        snap2 = out_count[1];
        fork
            send_frame(1, 3);
            begin
                wait_cycles(10);
                check(accepted[1] == snap, "R4 no words accepted while paused", 64'(accepted[1] - snap), 64'd0);
                pause_async = 4'b0000;
            end
        join
        wait_cycles(15);
        check(out_count[1] - snap2 == 3, "R4 held words delivered after release", 64'(out_count[1] - snap2), 64'd3);

        // R6 burst limit
        set_ready(1'b0);
        send_frame(0, 300);
        send_frame(1, 10);
        wait_cycles(3);
        clear_runs();
        set_ready(1'b1);
        wait_cycles(400);
        flush_runs();
        check(run_d.size() >= 2, "R6 run count", 64'(run_d.size()), 64'd2);
        if (run_d.size() >= 2) begin
            check(run_d[0] == 0 && run_l[0] == BURST, "R6 first grant capped", 64'(run_l[0]), 64'(BURST));
            check(run_d[1] == 1 && run_l[1] == 10, "R6 other channel served after cap", 64'(run_d[1]), 64'd1);
        end

        // R7 tlast ends grant, round-robin order
        set_ready(1'b0);
        send_frame(2, 3);
        send_frame(2, 3);
        send_frame(3, 3);
        wait_cycles(3);
        clear_runs();
        set_ready(1'b1);
        wait_cycles(30);
        flush_runs();
        check(run_d.size() == 3, "R7 run count", 64'(run_d.size()), 64'd3);
        if (run_d.size() == 3) begin
            check(run_d[0] == 2 && run_l[0] == 3, "R7 first frame ch2", 64'(run_d[0]), 64'd2);
            check(run_d[1] == 3 && run_l[1] == 3, "R7 rotate to ch3", 64'(run_d[1]), 64'd3);
            check(run_d[2] == 2 && run_l[2] == 3, "R7 wrap back to ch2", 64'(run_d[2]), 64'd2);
        end

        // R8 FIFO full
        set_ready(1'b0);
        snap = accepted[0];
        snap2 = out_count[0];
        fork
            send_frame(0, DEPTH + 4);
        join_none
        wait_cycles(DEPTH + 60);
        check(accepted[0] - snap == DEPTH, "R8 accepted words at full", 64'(accepted[0] - snap), 64'(DEPTH));
        #1;
        check(s_tready[0] == 1'b0, "R8 ready low at full", 64'(s_tready[0]), 64'd0);
        set_ready(1'b1);
        wait (accepted[0] - snap == DEPTH + 4);
        wait_cycles(DEPTH + 40);
        check(out_count[0] - snap2 == DEPTH + 4, "R8 no word lost", 64'(out_count[0] - snap2), 64'(DEPTH + 4));

        // Random phase across all channels
        rand_ready = 1;
        rand_on = 1;
        drivers_done = 0;
        for (int c = 0; c < CH; c++) begin
            fork
                automatic int cc = c;
                begin
                    for (int f = 0; f < 25; f++) begin
                        send_frame(cc, 1 + int'($urandom % 40));
                        wait_cycles(int'($urandom % 6));
                    end
                    drivers_done++;
                end
            join_none
        end
        fork
            begin
                while (rand_on) begin
                    wait_cycles(30 + int'($urandom % 170));
                    link_ready = (($urandom % 4) != 0);
                end
            end
            begin
                while (rand_on) begin
                    wait_cycles(20 + int'($urandom % 60));
                    pause_async = 4'($urandom) & 4'($urandom);
                end
            end
        join_none
        wait (drivers_done == CH);
        rand_on = 0;
        @(negedge clk);
        link_ready = 1'b1;
        pause_async = '0;
        rand_ready = 0;
        m_tready = 1'b1;
        wait_cycles(3000);
        for (int c = 0; c < CH; c++)
            check(expq[c].size() == 0, "R5 all expected words delivered", 64'(expq[c].size()), 64'd0);

        summary();
        $finish;
    end

endmodule